// File: doc/BRIEF.md
# Widening pairwise SIMD adder

This block takes one 64-bit packed operand and adds each pair of neighbouring lanes. Every sum is written into a result lane twice as wide as a source lane, so the packed result has half as many lanes as the operand. Two lane sizes are supported: 8-bit source lanes give four 16-bit sums, and 16-bit source lanes give two 32-bit sums. A second control picks whether each source lane is read as a signed or an unsigned number before it is widened.

Each request is marked by a valid strobe. The result is registered and comes out one clock later with its own valid strobe. It stays on the output until the next accepted request. A doubled lane always has room for the sum, so no saturation or carry-out exists.

Top module: `wide_pair_adder`

## Requirements
- R1: With `in_size`=0 (8-bit source lanes), result bits [16k+15:16k] equal byte 2k plus byte 2k+1 of `in_data` (byte j is bits [8j+7:8j]), each widened to 16 bits, for k = 0..3.
- R2: With `in_size`=1 (16-bit source lanes), result bits [32k+31:32k] equal halfword 2k plus halfword 2k+1 of `in_data` (halfword j is bits [16j+15:16j]), each widened to 32 bits, for k = 0..1.
- R3: With `in_signed`=1 each source lane is sign-extended before the addition. Example: bytes 0x80 and 0x80 give 0xFF00.
- R4: With `in_signed`=0 each source lane is zero-extended before the addition. Example: bytes 0xFF and 0xFF give 0x01FE.
- R5: The extreme lane values give exact sums with no wrap. Signed halfwords 0x8000+0x8000 give 0xFFFF0000, 0x7FFF+0x7FFF give 0x0000FFFE, and unsigned 0xFFFF+0xFFFF gives 0x0001FFFE.
- R6: `out_valid` is high in the cycle after each cycle in which `in_valid` was high at the clock edge, and low otherwise. `out_data` carries that request's result in the same cycle.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero on the next clock edge.
- R8: While `in_valid` is low, `out_data` keeps its last value whatever `in_data`, `in_size` and `in_signed` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Packed source operand |
| in_size | input | 1 | Source lane size: 0 for 8-bit, 1 for 16-bit |
| in_signed | input | 1 | 1 selects sign extension, 0 selects zero extension |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 64 | Packed widened pairwise sums |

## Verification
Two things can happen in the same cycle. A new request is captured while the previous result is still being presented, and the lane size or signedness can change from one request to the next. The bench provokes this with long runs of back-to-back requests whose size, signedness and operand change every cycle. Each result is checked one cycle after its request against an independent model. It must match that request's settings and never the neighbouring request's. Runs with the strobe held low use fresh random operands to show that the held result does not change.

// File: rtl/wide_pair_adder_pkg.sv
package wide_pair_adder_pkg;

  typedef enum logic {
    LANE8  = 1'b0,
    LANE16 = 1'b1
  } lane_size_e;

  localparam int unsigned NARROW_W = 8;
  localparam int unsigned WIDE_W   = 16;

endpackage

// File: rtl/pair_sum.sv
module pair_sum #(
  parameter int unsigned SRC_W = 8,
  localparam int unsigned DST_W = 2 * SRC_W
) (
  input  logic [SRC_W-1:0] lo_lane,
  input  logic [SRC_W-1:0] hi_lane,
  input  logic             sgn,
  output logic [DST_W-1:0] sum
);

  function automatic logic [DST_W-1:0] widen(logic [SRC_W-1:0] v, logic s);
    return {{SRC_W{s & v[SRC_W-1]}}, v};
  endfunction

  logic [DST_W-1:0] lo_wide;
  logic [DST_W-1:0] hi_wide;

  assign lo_wide = widen(lo_lane, sgn);
  assign hi_wide = widen(hi_lane, sgn);
  assign sum     = lo_wide + hi_wide;

endmodule

// File: rtl/lane_pair_array.sv
module lane_pair_array #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SRC_W  = 8,
  localparam int unsigned NPAIR = DATA_W / (2 * SRC_W),
  localparam int unsigned DST_W = 2 * SRC_W
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              sgn,
  output logic [DATA_W-1:0] packed_sum
);

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    pair_sum #(.SRC_W(SRC_W)) u_sum (
      .lo_lane (operand[(2*k)*SRC_W +: SRC_W]),
      .hi_lane (operand[(2*k+1)*SRC_W +: SRC_W]),
      .sgn     (sgn),
      .sum     (packed_sum[k*DST_W +: DST_W])
    );
  end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] d,
  output logic              q_valid,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= capture;
      if (capture) begin
        q <= d;
      end
    end
  end

endmodule

// File: rtl/wide_pair_adder.sv
module wide_pair_adder
  import wide_pair_adder_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_size,
  input  logic              in_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] narrow_res;
  logic [DATA_W-1:0] wide_res;
  logic [DATA_W-1:0] sel_res;
  lane_size_e        size_sel;

  assign size_sel = lane_size_e'(in_size);

  lane_pair_array #(.DATA_W(DATA_W), .SRC_W(NARROW_W)) u_narrow (
    .operand    (in_data),
    .sgn        (in_signed),
    .packed_sum (narrow_res)
  );

  lane_pair_array #(.DATA_W(DATA_W), .SRC_W(WIDE_W)) u_wide (
    .operand    (in_data),
    .sgn        (in_signed),
    .packed_sum (wide_res)
  );

  assign sel_res = (size_sel == LANE16) ? wide_res : narrow_res;

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .capture (in_valid),
    .d       (sel_res),
    .q_valid (out_valid),
    .q       (out_data)
  );

endmodule

// File: rtl/wide_pair_adder_chk.sv
module wide_pair_adder_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_size,
  input logic              in_signed,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  function automatic logic [DATA_W-1:0] model(logic [DATA_W-1:0] d, logic sz, logic sg);
    logic [DATA_W-1:0] r;
    logic [31:0] x;
    logic [31:0] y;
    r = '0;
    if (!sz) begin
      for (int k = 0; k < DATA_W / 16; k++) begin
        x = {24'h0, d[16*k +: 8]};
        y = {24'h0, d[16*k+8 +: 8]};
        if (sg && x[7]) x = x - 32'h100;
        if (sg && y[7]) y = y - 32'h100;
        r[16*k +: 16] = 16'(x + y);
      end
    end else begin
      for (int k = 0; k < DATA_W / 32; k++) begin
        x = {16'h0, d[32*k +: 16]};
        y = {16'h0, d[32*k+16 +: 16]};
        if (sg && x[15]) x = x - 32'h10000;
        if (sg && y[15]) y = y - 32'h10000;
        r[32*k +: 32] = x + y;
      end
    end
    return r;
  endfunction

  p_bytes_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_size) |=> (out_data == $past(model(in_data, 1'b0, in_signed))));

  p_halves_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size) |=> (out_data == $past(model(in_data, 1'b1, in_signed))));

  p_sign_ext_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed && !in_size) |=> (out_data[15:9] == {7{out_data[8]}}));

  p_zero_ext_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed && !in_size) |=> (out_data[15:9] == 7'h00));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed && in_size) |=> (out_data[31:17] == {15{out_data[16]}}));

  p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

endmodule

bind wide_pair_adder wide_pair_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_size   (in_size),
  .in_signed (in_signed),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_wide_pair_adder.sv
module sim_wide_pair_adder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_size = 1'b0;
  logic        in_signed = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wide_pair_adder u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_size   (in_size),
    .in_signed (in_signed),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [63:0] expect_sum(logic [63:0] d, logic sz, logic sg);
    logic [63:0] r;
    int a;
    int b;
    r = '0;
    if (!sz) begin
      for (int k = 0; k < 4; k++) begin
        a = int'(d[16*k +: 8]);
        b = int'(d[16*k+8 +: 8]);
        if (sg && a > 127) a = a - 256;
        if (sg && b > 127) b = b - 256;
        r[16*k +: 16] = 16'(a + b);
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        a = int'(d[32*k +: 16]);
        b = int'(d[32*k+16 +: 16]);
        if (sg && a > 32767) a = a - 65536;
        if (sg && b > 32767) b = b - 65536;
        r[32*k +: 32] = 32'(a + b);
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, check its result at the next falling edge
  task automatic request(string tag, logic [63:0] d, logic sz, logic sg, logic [63:0] exp);
    in_valid  = 1'b1;
    in_data   = d;
    in_size   = sz;
    in_signed = sg;
    @(negedge clk);
    check({tag, " valid R6"}, {63'h0, out_valid}, 64'h1);
    check(tag, out_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [63:0] held;
    logic sz;
    logic sg;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R7 reset valid", {63'h0, out_valid}, 64'h0);
    check("R7 reset data", out_data, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 idle valid", {63'h0, out_valid}, 64'h0);

    request("R4 R1 u8 all ones", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 64'h01FE_01FE_01FE_01FE);
    request("R3 R1 s8 min", 64'h8080_8080_8080_8080, 1'b0, 1'b1, 64'hFF00_FF00_FF00_FF00);
    request("R3 R1 s8 max", 64'h7F7F_7F7F_7F7F_7F7F, 1'b0, 1'b1, 64'h00FE_00FE_00FE_00FE);
    request("R3 R1 s8 mixed", 64'h7F80_807F_0001_FF01, 1'b0, 1'b1, 64'hFFFF_FFFF_0001_0000);
    request("R5 R2 s16 min", 64'h8000_8000_8000_8000, 1'b1, 1'b1, 64'hFFFF_0000_FFFF_0000);
    request("R5 R2 s16 max", 64'h7FFF_7FFF_7FFF_7FFF, 1'b1, 1'b1, 64'h0000_FFFE_0000_FFFE);
    request("R5 R4 u16 all ones", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 64'h0001_FFFE_0001_FFFE);
    request("R2 u16 lanes", 64'h0003_0004_1000_2000, 1'b1, 1'b0, 64'h0000_0007_0000_3000);

    // back-to-back random requests, settings change every cycle
    for (int i = 0; i < 600; i++) begin
      d  = {$urandom, $urandom};
      sz = 1'($urandom);
      sg = 1'($urandom);
      if (i % 7 == 0) d = sz ? 64'h8000_7FFF_7FFF_8000 : 64'h807F_7F80_8080_7F7F;
      request(sz ? "R2 random" : "R1 random", d, sz, sg, expect_sum(d, sz, sg));
    end

    // hold: strobe low, inputs churn
    held = out_data;
    for (int i = 0; i < 20; i++) begin
      in_valid  = 1'b0;
      in_data   = {$urandom, $urandom};
      in_size   = 1'($urandom);
      in_signed = 1'($urandom);
      @(negedge clk);
      check("R8 hold data", out_data, held);
      check("R6 valid low", {63'h0, out_valid}, 64'h0);
    end

    request("R1 after idle", 64'h0102_0304_0506_0708, 1'b0, 1'b0, 64'h0003_0007_000B_000F);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset valid", {63'h0, out_valid}, 64'h0);
    check("R7 mid reset data", out_data, 64'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule